// File: doc/BRIEF.md
# Single Bit Test and Modify Unit

This unit carries out the four single-bit instructions of a processor execute stage. Each one picks one bit of an operand, reports the old state of that bit in the zero flag, and then leaves the bit alone, forces it high, forces it low, or inverts it. The operand is either a 32-bit data register or a byte fetched from memory. The bit number comes from an immediate field or from the low byte of a data register, and it wraps to the width of the operand.

The execute stage presents the operand, the bit number, the operation, the operand kind and the current flags together with a valid strobe. One clock later the unit returns a done pulse with the new operand value, a write-back enable and the updated flag vector. Only the zero flag changes. Fetching operands and accessing memory belong to the surrounding pipeline.

Top module: `bit_modify_unit`

## Requirements
- R1: The result's zero flag (bit 2 of the flag vector) equals the inverse of the selected bit as it was before the operation, so it is 1 when that bit was 0.
- R2: The flag bits X (bit 4), N (bit 3), V (bit 1) and C (bit 0) are copied unchanged from the input flags into the result.
- R3: Operation code 0 (test) returns the operand unchanged, with any byte operand limited to its low 8 bits, and deasserts write-back enable.
- R4: Operation code 1 (set) returns the operand with the selected bit forced to 1.
- R5: Operation code 2 (clear) returns the operand with the selected bit forced to 0.
- R6: Operation code 3 (change) returns the operand with the selected bit inverted.
- R7: When `in_use_reg` is 1 the bit number is taken from `in_reg_idx`. Otherwise it is taken from `in_imm_idx`.
- R8: For a byte operand (`in_mem_byte`=1) the bit number is taken modulo 8.
- R9: For a register operand (`in_mem_byte`=0) the bit number is taken modulo 32.
- R10: For a byte operand, bits 31..8 of the result operand are zero, whatever the input's upper bits hold.
- R11: `out_done` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R12: Write-back enable is asserted for operation codes 1, 2 and 3.
- R13: While reset is asserted, and immediately after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 test, 1 set, 2 clear, 3 change |
| in_mem_byte | input | 1 | 1: the operand is a memory byte; 0: a 32-bit register |
| in_use_reg | input | 1 | 1: the bit number comes from the register field |
| in_imm_idx | input | 8 | Immediate bit number |
| in_reg_idx | input | 8 | Low byte of the register that holds the bit number |
| in_operand | input | 32 | Operand value |
| in_flags | input | 5 | Current flags {X,N,Z,V,C} |
| out_done | output | 1 | Result valid pulse |
| out_operand | output | 32 | Modified operand |
| out_wr_en | output | 1 | Write-back enable |
| out_flags | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
The selected-bit index lives only in combinational logic, and every result is registered at the next edge. A wrong index, a wrong wrap or a wrong source choice therefore appears one cycle after the strobe, both as a bad zero flag and as a wrong bit flipped in the operand. A stuck done register or write-enable register shows at the first result that follows. Leakage of upper bits in byte mode is exposed by feeding byte operands whose upper bits are not zero.

// File: rtl/bit_modify_pkg.sv
package bit_modify_pkg;
  localparam int FLAG_W = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_V  = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_N  = 3;
  localparam int FLG_X  = 4;

  typedef enum logic [1:0] {
    BOP_TEST  = 2'd0,
    BOP_SET   = 2'd1,
    BOP_CLEAR = 2'd2,
    BOP_FLIP  = 2'd3
  } bop_e;
endpackage

// File: rtl/bit_index_sel.sv
module bit_index_sel #(
  parameter int IDX_IN_W = 8,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8
) (
  input  logic                use_reg,
  input  logic                mem_byte,
  input  logic [IDX_IN_W-1:0] imm_idx,
  input  logic [IDX_IN_W-1:0] reg_idx,
  output logic [IDX_IN_W-1:0] bit_idx
);
  localparam logic [IDX_IN_W-1:0] WRAP_REG  = IDX_IN_W'(DATA_W);
  localparam logic [IDX_IN_W-1:0] WRAP_BYTE = IDX_IN_W'(BYTE_W);

  logic [IDX_IN_W-1:0] raw_idx;

  always_comb begin
    raw_idx = use_reg ? reg_idx : imm_idx;
    bit_idx = mem_byte ? (raw_idx % WRAP_BYTE) : (raw_idx % WRAP_REG);
  end
endmodule

// File: rtl/bit_modify_core.sv
module bit_modify_core
  import bit_modify_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int IDX_IN_W = 8
) (
  input  logic [DATA_W-1:0]   operand,
  input  logic [IDX_IN_W-1:0] bit_idx,
  input  logic [1:0]          op,
  input  logic                mem_byte,
  output logic [DATA_W-1:0]   result,
  output logic                old_bit,
  output logic                wr_en
);
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] sel_mask;

  always_comb begin
    src      = mem_byte ? (operand & BYTE_MASK) : operand;
    sel_mask = ONE << bit_idx;
    old_bit  = |(src & sel_mask);
    wr_en    = (op != BOP_TEST);
    case (bop_e'(op))
      BOP_SET:   result = src | sel_mask;
      BOP_CLEAR: result = src & ~sel_mask;
      BOP_FLIP:  result = src ^ sel_mask;
      default:   result = src;
    endcase
  end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bit_modify_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int IDX_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          in_op,
  input  logic                in_mem_byte,
  input  logic                in_use_reg,
  input  logic [IDX_IN_W-1:0] in_imm_idx,
  input  logic [IDX_IN_W-1:0] in_reg_idx,
  input  logic [DATA_W-1:0]   in_operand,
  input  logic [FLAG_W-1:0]   in_flags,
  output logic                out_done,
  output logic [DATA_W-1:0]   out_operand,
  output logic                out_wr_en,
  output logic [FLAG_W-1:0]   out_flags
);
  logic [IDX_IN_W-1:0] bit_idx;
  logic [DATA_W-1:0]   nxt_operand;
  logic                nxt_old_bit;
  logic                nxt_wr_en;
  logic [FLAG_W-1:0]   nxt_flags;

  bit_index_sel #(.IDX_IN_W(IDX_IN_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_idx (
    .use_reg (in_use_reg),
    .mem_byte(in_mem_byte),
    .imm_idx (in_imm_idx),
    .reg_idx (in_reg_idx),
    .bit_idx (bit_idx)
  );

  bit_modify_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_IN_W(IDX_IN_W)) u_core (
    .operand (in_operand),
    .bit_idx (bit_idx),
    .op      (in_op),
    .mem_byte(in_mem_byte),
    .result  (nxt_operand),
    .old_bit (nxt_old_bit),
    .wr_en   (nxt_wr_en)
  );

  always_comb begin
    nxt_flags        = in_flags;
    nxt_flags[FLG_Z] = ~nxt_old_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done    <= 1'b0;
      out_operand <= '0;
      out_wr_en   <= 1'b0;
      out_flags   <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_operand <= nxt_operand;
        out_wr_en   <= nxt_wr_en;
        out_flags   <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/bit_modify_unit_chk.sv
module bit_modify_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int IDX_IN_W = 8,
  parameter int FLAG_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic                in_mem_byte,
  input logic                in_use_reg,
  input logic [IDX_IN_W-1:0] in_imm_idx,
  input logic [IDX_IN_W-1:0] in_reg_idx,
  input logic [DATA_W-1:0]   in_operand,
  input logic [FLAG_W-1:0]   in_flags,
  input logic                out_done,
  input logic [DATA_W-1:0]   out_operand,
  input logic                out_wr_en,
  input logic [FLAG_W-1:0]   out_flags
);
  logic [IDX_IN_W-1:0] pick;
  logic [IDX_IN_W-1:0] pos;
  logic [DATA_W-1:0]   view;
  always_comb begin
    pick = in_use_reg ? in_reg_idx : in_imm_idx;
    pos  = in_mem_byte ? IDX_IN_W'(pick % IDX_IN_W'(BYTE_W)) : IDX_IN_W'(pick % IDX_IN_W'(DATA_W));
    view = in_mem_byte ? {{(DATA_W-BYTE_W){1'b0}}, in_operand[BYTE_W-1:0]} : in_operand;
  end

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_flags[2] == ~$past(view[pos])); // R1
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_flags[4:3] == $past(in_flags[4:3])) && (out_flags[1:0] == $past(in_flags[1:0]))); // R2
  AST_TEST_SAME: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd0) |=> out_operand == $past(view)); // R3
  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mem_byte) |=> out_operand[DATA_W-1:BYTE_W] == '0); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_done); // R11
  AST_WRITE_EN: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_wr_en == ($past(in_op) != 2'd0)); // R12
endmodule

bind bit_modify_unit bit_modify_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_IN_W(IDX_IN_W), .FLAG_W(bit_modify_pkg::FLAG_W)
) u_chk (.*);

// File: tb/bit_modify_unit_tb.sv
module bit_modify_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] operand;
    logic        wr;
    logic [4:0]  flags;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [1:0]  in_op = 0;
  logic        in_mem_byte = 0;
  logic        in_use_reg = 0;
  logic [7:0]  in_imm_idx = 0;
  logic [7:0]  in_reg_idx = 0;
  logic [31:0] in_operand = 0;
  logic [4:0]  in_flags = 0;
  logic        out_done;
  logic [31:0] out_operand;
  logic        out_wr_en;
  logic [4:0]  out_flags;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_modify_unit u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic mem, input logic use_reg,
                      input logic [7:0] imm, input logic [7:0] rg,
                      input logic [31:0] opnd, input logic [4:0] fl, input string tag);
    exp_t e;
    logic [7:0]  n;
    logic [31:0] src;
    logic [31:0] m;
    n   = use_reg ? rg : imm;
    n   = mem ? (n & 8'd7) : (n & 8'd31);
    src = mem ? {24'd0, opnd[7:0]} : opnd;
    m   = 32'd1 << n;
    case (op)
      2'd1: e.operand = src | m;
      2'd2: e.operand = src & ~m;
      2'd3: e.operand = src ^ m;
      default: e.operand = src;
    endcase
    e.wr = (op != 2'd0);
    e.flags = fl;
    e.flags[2] = ((src & m) == 0);
    e.tag = tag;
    @(negedge clk);
    in_valid = 1; in_op = op; in_mem_byte = mem; in_use_reg = use_reg;
    in_imm_idx = imm; in_reg_idx = rg; in_operand = opnd; in_flags = fl;
    sb.push_back(e);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check("R11 done low after idle", {31'd0, out_done}, 32'd0);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst && out_done) begin
      if (sb.size() == 0) begin
        check("R11 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " operand"}, out_operand, e.operand);
        check({e.tag, " wr_en R12"}, {31'd0, out_wr_en}, {31'd0, e.wr});
        check({e.tag, " flags R1 R2"}, {27'd0, out_flags}, {27'd0, e.flags});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset done", {31'd0, out_done}, 32'd0);
    check("R13 reset operand", out_operand, 32'd0);
    check("R13 reset flags", {27'd0, out_flags}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R13 after reset wr_en", {31'd0, out_wr_en}, 32'd0);

    send(2'd0, 0, 0, 8'd4,  8'd0,  32'h0000_0010, 5'b11111, "R3 test set bit");
    send(2'd0, 0, 0, 8'd5,  8'd0,  32'h0000_0010, 5'b00000, "R3 test clear bit");
    send(2'd1, 0, 0, 8'd31, 8'd0,  32'h1234_5678, 5'b10011, "R4 set bit31");
    send(2'd2, 0, 0, 8'd3,  8'd0,  32'hFFFF_FFFF, 5'b01000, "R5 clear bit3");
    send(2'd3, 0, 0, 8'd0,  8'd0,  32'h0000_0001, 5'b10101, "R6 change bit0");
    send(2'd3, 0, 0, 8'd16, 8'd0,  32'h0000_0000, 5'b01010, "R6 change bit16");
    send(2'd1, 0, 1, 8'd0,  8'd9,  32'h0000_0000, 5'b00100, "R7 reg source");
    send(2'd1, 0, 0, 8'd9,  8'd2,  32'h0000_0000, 5'b00100, "R7 imm source");
    send(2'd2, 0, 1, 8'd0,  8'd37, 32'hFFFF_FFFF, 5'b11011, "R9 reg modulo 32");
    send(2'd1, 0, 0, 8'd200, 8'd0, 32'h0, 5'b00001, "R9 imm modulo 32");
    idle_check();
    send(2'd1, 1, 0, 8'd11, 8'd0,  32'hABCD_EF00, 5'b11011, "R8 R10 byte modulo 8");
    send(2'd0, 1, 1, 8'd0,  8'd15, 32'hFFFF_FF7F, 5'b00000, "R8 R3 byte test");
    send(2'd3, 1, 0, 8'd7,  8'd0,  32'h5555_5580, 5'b10001, "R10 byte change");
    send(2'd2, 1, 1, 8'd0,  8'd2,  32'hFFFF_FFFF, 5'b01110, "R10 R5 byte clear");
    idle_check();
    repeat (3) @(negedge clk);
    check("R11 all results returned", sb.size(), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule